// File: doc/BRIEF.md
# Table-Driven Decision Feedback Equalizer

This block equalizes a stream of binary antipodal symbols. It takes one signed fixed-point sample per valid cycle from a feedforward filter outside the block. It subtracts an estimate of the post-cursor intersymbol interference from that sample, then slices the difference into a hard decision. The estimate comes only from decisions the block has already made. It is never computed from raw received samples.

The feedback path has no multipliers. The last few decisions form an address into a small table. Each table entry holds the sum of the feedback coefficients, each coefficient signed by one pattern of past decisions. The entries depend only on the feedback coefficients, so an adaptation engine outside the block can rebuild them without the feedforward output. It then loads them through a write port whenever the coefficients change.

The decision loop closes in one cycle. The block outputs the equalized soft value and the decision as registers, with a valid flag that follows the input valid flag.

Top module: `dfe_lut_eq`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `out_soft` and `out_dec` to 0. It also clears the decision history, so the first sample after reset uses table entry 0.
- R2: For a valid sample, `out_soft` becomes the input sample minus the table entry at the history address. The history address is 4 bits: bit 0 is the newest decision and bit 3 is the oldest.
- R3: The subtraction saturates to the 16-bit signed range instead of wrapping. Results above 32767 become 32767, and results below -32768 become -32768.
- R4: `out_dec` is 1 when the equalized value is zero or positive, and 0 when it is negative. A decision of 1 stands for +1 and a decision of 0 stands for -1.
- R5: The decision for the valid sample in one cycle is shifted into address bit 0 for the next valid sample. The older decisions move up one bit, and the oldest decision drops out.
- R6: `out_valid` equals `in_valid` from the previous cycle.
- R7: A table write lands at the clock edge. A lookup in the same cycle still sees the old entry, and lookups from the next cycle on see the new entry.
- R8: A cycle with `in_valid` low leaves the decision history, `out_soft` and `out_dec` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_sample` as valid this cycle |
| in_sample | input | 16 | Feedforward filter output, signed two's complement |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | 4 | Table entry index, the decision pattern with the newest decision at bit 0 |
| tbl_wr_data | input | 16 | Precomputed signed tap sum for that pattern |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_soft | output | 16 | Saturated equalized value, signed |
| out_dec | output | 1 | Hard decision: 1 for +1, 0 for -1 |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic. They also assume that the inputs carry no unknown values, and that every table entry is written before a valid sample can address it. The table is left unreset, like block memory. The bench therefore loads all 16 entries before its first sample. After that it mixes random writes, valid gaps and extreme sample and table values. This drives both saturation directions, ties that land exactly at zero, and writes that land in the same cycle as a lookup of the entry being written.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int DFE_DATA_W = 16;
  localparam int DFE_TAPS   = 4;

  // Decision bit encoding: 1 stands for +1, 0 stands for -1.
  localparam logic DEC_POS = 1'b1;
  localparam logic DEC_NEG = 1'b0;
endpackage

// File: rtl/dfe_tap_table.sv
module dfe_tap_table #(
  parameter int DATA_W = dfe_pkg::DFE_DATA_W,
  parameter int ADDR_W = dfe_pkg::DFE_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  // Distributed memory: write at the edge, asynchronous read.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R7: a write is visible from the following cycle
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/dfe_history.sv
module dfe_history #(
  parameter int TAPS = dfe_pkg::DFE_TAPS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            dec_in,
  output logic [TAPS-1:0] hist
);
  logic [TAPS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q[0] <= 1'b0;
    else if (shift_en) hist_q[0] <= dec_in;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)           hist_q[i] <= 1'b0;
      else if (shift_en) hist_q[i] <= hist_q[i-1];
    end
  end

  assign hist = hist_q;

  // R5: newest decision enters bit 0, older ones move up one place
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(dec_in)) &&
                 (hist_q[TAPS-1:1] == $past(hist_q[TAPS-2:0])));

  // R8: no valid sample, no history movement
  p_hist_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
  parameter int DATA_W = dfe_pkg::DFE_DATA_W
) (
  input  logic [DATA_W-1:0] ffe_in,
  input  logic [DATA_W-1:0] fb_est,
  output logic [DATA_W-1:0] eq_val,
  output logic              dec
);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] diff;

  always_comb begin
    diff = {ffe_in[DATA_W-1], ffe_in} - {fb_est[DATA_W-1], fb_est};
    if (diff[DATA_W] != diff[DATA_W-1])
      eq_val = diff[DATA_W] ? NEG_MIN : POS_MAX;
    else
      eq_val = diff[DATA_W-1:0];
    dec = eq_val[DATA_W-1] ? dfe_pkg::DEC_NEG : dfe_pkg::DEC_POS;
  end

  // R3: non-negative minus negative never wraps to a negative value,
  // and negative minus non-negative never wraps to a non-negative value
  always_comb begin
    if (!ffe_in[DATA_W-1] && fb_est[DATA_W-1])
      p_sat_high_r3: assert (!eq_val[DATA_W-1]);
    if (ffe_in[DATA_W-1] && !fb_est[DATA_W-1])
      p_sat_low_r3: assert (eq_val[DATA_W-1]);
  end
endmodule

// File: rtl/dfe_lut_eq.sv
module dfe_lut_eq #(
  parameter int DATA_W = dfe_pkg::DFE_DATA_W,
  parameter int TAPS   = dfe_pkg::DFE_TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              tbl_wr_en,
  input  logic [TAPS-1:0]   tbl_wr_addr,
  input  logic [DATA_W-1:0] tbl_wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_soft,
  output logic              out_dec
);
  logic [TAPS-1:0]   hist;
  logic [DATA_W-1:0] fb_est;
  logic [DATA_W-1:0] eq_val;
  logic              dec;

  dfe_tap_table #(.DATA_W(DATA_W), .ADDR_W(TAPS)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr_en),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_addr (hist),
    .rd_data (fb_est)
  );

  dfe_slicer #(.DATA_W(DATA_W)) u_slicer (
    .ffe_in (in_sample),
    .fb_est (fb_est),
    .eq_val (eq_val),
    .dec    (dec)
  );

  dfe_history #(.TAPS(TAPS)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .dec_in   (dec),
    .hist     (hist)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_soft  <= '0;
      out_dec   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_soft <= eq_val;
        out_dec  <= dec;
      end
    end
  end

  // R6: output valid trails input valid by one cycle
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R4: the registered decision agrees with the sign of the registered soft value
  p_dec_sign_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dec == !out_soft[DATA_W-1]));

  // R8: idle cycles keep the outputs
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_soft) && $stable(out_dec)));
endmodule

// File: tb/tb_dfe_lut_eq.sv
module tb_dfe_lut_eq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic        tbl_wr_en = 1'b0;
  logic [3:0]  tbl_wr_addr = '0;
  logic [15:0] tbl_wr_data = '0;
  logic        out_valid;
  logic [15:0] out_soft;
  logic        out_dec;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [15:0] tbl_m [16];
  logic [3:0]  hist_m = '0;
  logic [15:0] soft_m = '0;
  logic        dec_m  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dfe_lut_eq dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .out_valid(out_valid), .out_soft(out_soft), .out_dec(out_dec)
  );

  function automatic logic [15:0] sat_diff(logic [15:0] s, logic [15:0] t);
    int d;
    d = int'($signed(s)) - int'($signed(t));
    if (d > 32767)  d = 32767;
    if (d < -32768) d = -32768;
    return d[15:0];
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive inputs, update the model, check the registered outputs.
  task automatic step(input logic v, input logic [15:0] s, input logic w,
                      input logic [3:0] wa, input logic [15:0] wd, input string tag);
    @(negedge clk);
    in_valid = v; in_sample = s;
    tbl_wr_en = w; tbl_wr_addr = wa; tbl_wr_data = wd;
    if (v) begin
      soft_m = sat_diff(s, tbl_m[hist_m]);   // lookup sees the old entry (R7)
      dec_m  = ~soft_m[15];
      hist_m = {hist_m[2:0], dec_m};
    end
    if (w) tbl_m[wa] = wd;
    @(posedge clk);
    #1;
    check(tag, "out_valid", int'(out_valid), int'(v));
    check(tag, "out_soft", int'($signed(out_soft)), int'($signed(soft_m)));
    check(tag, "out_dec", int'(out_dec), int'(dec_m));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b0, 16'h0000, 1'b1, a, d, "R7");
  endtask

  task automatic sample(input logic [15:0] s, input string tag);
    step(1'b1, s, 1'b0, 4'd0, 16'h0000, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d;
    logic [3:0]  a;
    logic        v, w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state of the outputs
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "out_soft after reset", int'(out_soft), 0);
    check("R1", "out_dec after reset", int'(out_dec), 0);

    // Load distinct entries: entry k holds 100*k + 7
    for (int k = 0; k < 16; k++) wr(4'(k), 16'(100 * k + 7));
    // R1/R2: first sample after reset addresses entry 0 -> 50 - 7 = 43
    sample(16'd50, "R1");
    check("R1", "history-zero lookup", int'($signed(out_soft)), 43);
    // R5: history now 0001, next lookup uses entry 1 (107): 100 - 107 = -7 -> dec 0
    sample(16'd100, "R5");
    check("R5", "entry after one +1", int'($signed(out_soft)), -7);
    // R5: history 0010 -> entry 2 (207)
    sample(16'd300, "R5");
    check("R5", "entry after +1,-1", int'($signed(out_soft)), 93);
    // R8: idle keeps outputs and history; history 0101 -> entry 5 (507)
    idle("R8");
    idle("R8");
    check("R8", "held soft", int'($signed(out_soft)), 93);
    sample(16'd507, "R4");
    // R4: zero result slices to 1
    check("R4", "zero -> decision 1", int'(out_dec), 1);
    // history 1011 -> entry 11 (1107)
    sample(16'd1106, "R4");
    check("R4", "-1 -> decision 0", int'(out_dec), 0);

    // R3: saturation in both directions (all entries set to an extreme)
    for (int k = 0; k < 16; k++) wr(4'(k), 16'h8000);
    sample(16'h7FFF, "R3");
    check("R3", "positive clamp", int'($signed(out_soft)), 32767);
    for (int k = 0; k < 16; k++) wr(4'(k), 16'h7FFF);
    sample(16'h8000, "R3");
    check("R3", "negative clamp", int'($signed(out_soft)), -32768);

    // R7: write to the entry being looked up in the same cycle
    for (int k = 0; k < 16; k++) wr(4'(k), 16'd10);
    step(1'b1, 16'd30, 1'b1, hist_m, 16'd1000, "R7");
    check("R7", "same-cycle lookup uses old entry", int'($signed(out_soft)), 20);

    // Random traffic with occasional table writes and extremes
    for (int i = 0; i < 3000; i++) begin
      v = ($urandom % 4) != 0;
      w = ($urandom % 5) == 0;
      a = 4'($urandom);
      case ($urandom % 8)
        0: s = 16'h7FFF;
        1: s = 16'h8000;
        default: s = 16'($urandom);
      endcase
      d = ($urandom % 6 == 0) ? (($urandom % 2) ? 16'h8000 : 16'h7FFF) : 16'($urandom);
      step(v, s, w, a, d, v ? "R2" : "R6");
    end
    idle("R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule